// File: doc/BRIEF.md
# Landing-Pad Expected State Tracker

This block keeps the one-bit "landing pad expected" flag of a hart and carries it across privilege changes. The flag is raised by instruction retirement when an indirect jump has just executed and a landing-pad instruction must come next. It is lowered when that landing pad retires. On trap entry the flag is parked in a per-target-mode previous-state bit, and on return from a trap it is taken back from that bit. Each step is gated by a forward control-flow-integrity enable. That enable is picked from a different configuration bit for each privilege and virtualization mode.

The surrounding core supplies the current privilege and virtualization mode, four enable bits taken from the configuration registers, and an extension-present strap. It also supplies strobes for trap entry (with the target mode), supervisor return and machine return (with the mode being returned to), and set and clear requests from retirement. The two previous-state bits go out to the status-register read path. A separate output tells the hypervisor register-swap logic whether the supervisor previous-state bit belongs in the swapped set. The presence of the supervisor and hypervisor modes is fixed by parameters.

Top module: `lpad_track`

## Requirements
- R1: While `lp_ext_i` is 0 the enable `fcfi_en_o` is 0 in every mode, and no trap or return ever moves the flag into or out of a previous-state bit.
- R2: At user privilege (`priv_i`=2'b00) the enable equals `senv_lpe_i` when the supervisor mode exists, otherwise `menv_lpe_i`.
- R3: At supervisor privilege (2'b01) the enable equals `henv_lpe_i` when `virt_i` is 1 and the hypervisor mode exists, otherwise `menv_lpe_i`.
- R4: At machine privilege (2'b11) the enable equals `mlpe_i`. The reserved code 2'b10 gives 0.
- R5: On trap entry, if the enable of the pre-trap mode is 1, `elp_o` is copied into `mpelp_o` (when `trap_to_m_i`=1) or into `spelp_o` (when it is 0), one clock later. Otherwise both previous-state bits keep their values.
- R6: Every trap entry clears `elp_o` on the next clock, whatever the enable.
- R7: On supervisor return `spelp_o` is cleared. `elp_o` takes the old `spelp_o` if the enable computed from `ret_priv_i`/`ret_virt_i` is 1, and keeps its value otherwise.
- R8: On machine return the same rule applies with `mpelp_o` in place of `spelp_o`.
- R9: When strobes coincide, trap entry wins over machine return, machine return wins over supervisor return, and any of these wins over the retirement requests.
- R10: A retirement set request raises `elp_o` only when the current enable is 1. A clear request lowers it unconditionally. Set wins over clear.
- R11: `spelp_swap_o` is 1 exactly when the extension is present, the hypervisor mode exists, and `henv_lpe_i` is 1.
- R12: After reset `elp_o`, `spelp_o` and `mpelp_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_ext_i | input | 1 | Landing-pad extension present strap |
| priv_i | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| virt_i | input | 1 | Current virtualization mode |
| menv_lpe_i | input | 1 | Machine environment-config landing-pad enable |
| senv_lpe_i | input | 1 | Supervisor environment-config landing-pad enable |
| henv_lpe_i | input | 1 | Hypervisor environment-config landing-pad enable |
| mlpe_i | input | 1 | Machine security-config landing-pad enable |
| trap_i | input | 1 | Trap entry strobe |
| trap_to_m_i | input | 1 | Trap target: 1 machine, 0 supervisor |
| sret_i | input | 1 | Supervisor return strobe |
| mret_i | input | 1 | Machine return strobe |
| ret_priv_i | input | 2 | Privilege being returned to |
| ret_virt_i | input | 1 | Virtualization mode being returned to |
| lp_set_i | input | 1 | Retirement request to raise the flag |
| lp_clr_i | input | 1 | Retirement request to lower the flag |
| fcfi_en_o | output | 1 | Enable for the current mode |
| elp_o | output | 1 | Expected landing-pad flag |
| spelp_o | output | 1 | Supervisor previous-state bit |
| mpelp_o | output | 1 | Machine previous-state bit |
| spelp_swap_o | output | 1 | Supervisor previous-state bit belongs to the host/guest swap set |

## Verification
The bench builds two copies side by side on the same stimulus. One has both supervisor and hypervisor modes present, which reaches the hypervisor-enable path of R3 and the swap output of R11. The other has both modes absent, which makes user mode fall back to the machine enable and ignores the virtualization input. Random strobes fire often enough that trap entry, both returns and retirement requests coincide regularly, so the priority order of R9 is exercised together with the enable gating.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam int PRIV_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  typedef struct packed {
    logic menv;
    logic senv;
    logic henv;
    logic mlpe;
  } lpe_cfg_t;

  // Forward-CFI enable for a given mode.
  function automatic logic fcfi_enable(input logic s_present, input logic h_present,
                                       input logic ext, input logic [PRIV_W-1:0] priv,
                                       input logic virt, input lpe_cfg_t cfg);
    logic en;
    en = 1'b0;
    if (ext) begin
      unique case (priv)
        PRIV_U:  en = s_present ? cfg.senv : cfg.menv;
        PRIV_S:  en = (h_present && virt) ? cfg.henv : cfg.menv;
        PRIV_M:  en = cfg.mlpe;
        default: en = 1'b0;
      endcase
    end
    return en;
  endfunction
endpackage

// File: rtl/lpad_en_sel.sv
module lpad_en_sel
  import lpad_pkg::*;
#(
  parameter bit S_PRESENT = 1'b1,
  parameter bit H_PRESENT = 1'b1
) (
  input  logic              ext_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  lpe_cfg_t          cfg_i,
  output logic              en_o
);
  assign en_o = fcfi_enable(S_PRESENT, H_PRESENT, ext_i, priv_i, virt_i, cfg_i);

  always_comb begin
    if (ext_i == 1'b0) begin
      assert_no_ext_no_en_R1: assert (en_o == 1'b0);
    end
  end
endmodule

// File: rtl/lpad_state.sv
module lpad_state (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_trap,
  input  logic trap_to_m,
  input  logic ev_sret,
  input  logic ev_mret,
  input  logic ev_retire,
  input  logic set_req,
  input  logic clr_req,
  input  logic en_cur,
  input  logic en_ret,
  output logic elp_q,
  output logic spelp_q,
  output logic mpelp_q
);
  logic elp_d, spelp_d, mpelp_d;

  always_comb begin
    elp_d   = elp_q;
    spelp_d = spelp_q;
    mpelp_d = mpelp_q;
    if (ev_trap) begin
      if (en_cur) begin
        if (trap_to_m) mpelp_d = elp_q;
        else           spelp_d = elp_q;
      end
      elp_d = 1'b0;
    end else if (ev_mret) begin
      if (en_ret) elp_d = mpelp_q;
      mpelp_d = 1'b0;
    end else if (ev_sret) begin
      if (en_ret) elp_d = spelp_q;
      spelp_d = 1'b0;
    end else if (ev_retire) begin
      if (set_req && en_cur) elp_d = 1'b1;
      else if (clr_req)      elp_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elp_q   <= 1'b0;
      spelp_q <= 1'b0;
      mpelp_q <= 1'b0;
    end else begin
      elp_q   <= elp_d;
      spelp_q <= spelp_d;
      mpelp_q <= mpelp_d;
    end
  end

  assert_trap_clears_elp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> !elp_q);
  assert_trap_saves_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trap && trap_to_m && en_cur) |=> (mpelp_q == $past(elp_q)));
  assert_trap_saves_s_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trap && !trap_to_m && en_cur) |=> (spelp_q == $past(elp_q)));
  assert_trap_keeps_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trap && !en_cur) |=> ($stable(spelp_q) && $stable(mpelp_q)));
  assert_sret_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sret |=> !spelp_q);
  assert_mret_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mret |=> !mpelp_q);
  assert_set_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retire && set_req && !en_cur) |=> !$rose(elp_q));
endmodule

// File: rtl/lpad_track.sv
module lpad_track
  import lpad_pkg::*;
#(
  parameter bit S_PRESENT = 1'b1,
  parameter bit H_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_ext_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic              menv_lpe_i,
  input  logic              senv_lpe_i,
  input  logic              henv_lpe_i,
  input  logic              mlpe_i,
  input  logic              trap_i,
  input  logic              trap_to_m_i,
  input  logic              sret_i,
  input  logic              mret_i,
  input  logic [PRIV_W-1:0] ret_priv_i,
  input  logic              ret_virt_i,
  input  logic              lp_set_i,
  input  logic              lp_clr_i,
  output logic              fcfi_en_o,
  output logic              elp_o,
  output logic              spelp_o,
  output logic              mpelp_o,
  output logic              spelp_swap_o
);
  localparam int N_SEL = 2;  // 0: current mode, 1: mode returned to

  lpe_cfg_t          cfg;
  logic [PRIV_W-1:0] sel_priv [N_SEL];
  logic              sel_virt [N_SEL];
  logic              sel_en   [N_SEL];

  assign cfg = '{menv: menv_lpe_i, senv: senv_lpe_i, henv: henv_lpe_i, mlpe: mlpe_i};
  assign sel_priv[0] = priv_i;
  assign sel_virt[0] = virt_i;
  assign sel_priv[1] = ret_priv_i;
  assign sel_virt[1] = ret_virt_i;

  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    lpad_en_sel #(.S_PRESENT(S_PRESENT), .H_PRESENT(H_PRESENT)) u_sel (
      .ext_i  (lp_ext_i),
      .priv_i (sel_priv[g]),
      .virt_i (sel_virt[g]),
      .cfg_i  (cfg),
      .en_o   (sel_en[g])
    );
  end

  // Named events, in priority order.
  logic ev_trap, ev_mret, ev_sret, ev_retire;
  assign ev_trap   = trap_i;
  assign ev_mret   = mret_i && !trap_i;
  assign ev_sret   = sret_i && !mret_i && !trap_i;
  assign ev_retire = (lp_set_i || lp_clr_i) && !trap_i && !mret_i && !sret_i;

  lpad_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_trap   (ev_trap),
    .trap_to_m (trap_to_m_i),
    .ev_sret   (ev_sret),
    .ev_mret   (ev_mret),
    .ev_retire (ev_retire),
    .set_req   (lp_set_i),
    .clr_req   (lp_clr_i),
    .en_cur    (sel_en[0]),
    .en_ret    (sel_en[1]),
    .elp_q     (elp_o),
    .spelp_q   (spelp_o),
    .mpelp_q   (mpelp_o)
  );

  assign fcfi_en_o    = sel_en[0];
  assign spelp_swap_o = lp_ext_i && H_PRESENT && henv_lpe_i;

  assert_mret_over_sret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && sret_i && !trap_i) |=> !mpelp_o);
  assert_no_ext_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_ext_i && (trap_i || sret_i || mret_i)) |=> !$rose(spelp_o) && !$rose(mpelp_o));
endmodule

// File: tb/lpad_track_bench.sv
module lpad_track_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CYC      = 4000;
  localparam int WD_CYC     = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       ext, virt, menv, senv, henv, mlpe, trap, to_m, sret, mret, rvirt, lset, lclr;
  logic [1:0] priv, rpriv;

  logic fcfi [2], elp [2], spelp [2], mpelp [2], swp [2];

  lpad_track #(.S_PRESENT(1'b1), .H_PRESENT(1'b1)) u_lpad_track (
    .clk(clk), .rst_n(rst_n), .lp_ext_i(ext), .priv_i(priv), .virt_i(virt),
    .menv_lpe_i(menv), .senv_lpe_i(senv), .henv_lpe_i(henv), .mlpe_i(mlpe),
    .trap_i(trap), .trap_to_m_i(to_m), .sret_i(sret), .mret_i(mret),
    .ret_priv_i(rpriv), .ret_virt_i(rvirt), .lp_set_i(lset), .lp_clr_i(lclr),
    .fcfi_en_o(fcfi[0]), .elp_o(elp[0]), .spelp_o(spelp[0]), .mpelp_o(mpelp[0]),
    .spelp_swap_o(swp[0]));

  lpad_track #(.S_PRESENT(1'b0), .H_PRESENT(1'b0)) u_lpad_track_bare (
    .clk(clk), .rst_n(rst_n), .lp_ext_i(ext), .priv_i(priv), .virt_i(virt),
    .menv_lpe_i(menv), .senv_lpe_i(senv), .henv_lpe_i(henv), .mlpe_i(mlpe),
    .trap_i(trap), .trap_to_m_i(to_m), .sret_i(sret), .mret_i(mret),
    .ret_priv_i(rpriv), .ret_virt_i(rvirt), .lp_set_i(lset), .lp_clr_i(lclr),
    .fcfi_en_o(fcfi[1]), .elp_o(elp[1]), .spelp_o(spelp[1]), .mpelp_o(mpelp[1]),
    .spelp_swap_o(swp[1]));

  int total = 0;
  int bad   = 0;
  bit s_of [2] = '{1'b1, 1'b0};
  bit h_of [2] = '{1'b1, 1'b0};
  bit m_elp [2], m_sp [2], m_mp [2];
  string st_tag [2];

  function automatic bit ref_en(bit s, bit h, bit e, bit [1:0] p, bit v);
    if (!e) return 1'b0;
    if (p == 2'd3) return mlpe;
    if (p == 2'd0) return s ? senv : menv;
    if (p == 2'd1) return (h && v) ? henv : menv;
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, int d, bit got, bit exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s dut%0d %s got=%0b exp=%0b", tag, d, what, got, exp);
    end
  endtask

  task automatic drive_idle();
    {ext, virt, menv, senv, henv, mlpe, trap, to_m, sret, mret, rvirt, lset, lclr} = '0;
    priv = 2'd3; rpriv = 2'd0;
  endtask

  task automatic drive_rand();
    ext   = ($urandom_range(0, 7) != 0);
    priv  = 2'($urandom_range(0, 3));
    virt  = 1'($urandom_range(0, 1));
    menv  = 1'($urandom_range(0, 1));
    senv  = 1'($urandom_range(0, 1));
    henv  = 1'($urandom_range(0, 1));
    mlpe  = 1'($urandom_range(0, 1));
    trap  = ($urandom_range(0, 5) == 0);
    to_m  = 1'($urandom_range(0, 1));
    sret  = ($urandom_range(0, 4) == 0);
    mret  = ($urandom_range(0, 4) == 0);
    rpriv = 2'($urandom_range(0, 3));
    rvirt = 1'($urandom_range(0, 1));
    lset  = ($urandom_range(0, 2) == 0);
    lclr  = ($urandom_range(0, 3) == 0);
  endtask

  // Reference next-state, R5..R10.
  task automatic model_step(int d);
    bit ec, er, multi;
    ec = ref_en(s_of[d], h_of[d], ext, priv, virt);
    er = ref_en(s_of[d], h_of[d], ext, rpriv, rvirt);
    multi = (int'(trap) + int'(sret) + int'(mret) + int'(lset || lclr)) > 1;
    if (trap) begin
      st_tag[d] = multi ? "R9 trap-first" : "R5/R6 trap";
      if (ec) begin
        if (to_m) m_mp[d] = m_elp[d];
        else      m_sp[d] = m_elp[d];
      end
      m_elp[d] = 1'b0;
    end else if (mret) begin
      st_tag[d] = multi ? "R9 mret-first" : "R8 mret";
      if (er) m_elp[d] = m_mp[d];
      m_mp[d] = 1'b0;
    end else if (sret) begin
      st_tag[d] = multi ? "R9 sret-first" : "R7 sret";
      if (er) m_elp[d] = m_sp[d];
      m_sp[d] = 1'b0;
    end else if (lset && ec) begin
      st_tag[d] = "R10 set";
      m_elp[d] = 1'b1;
    end else if (lclr) begin
      st_tag[d] = "R10 clear";
      m_elp[d] = 1'b0;
    end else begin
      st_tag[d] = (!ext) ? "R1 hold" : "R10 hold";
    end
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    drive_idle();
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R12", "elp", d, elp[d], 1'b0);
      chk("R12", "spelp", d, spelp[d], 1'b0);
      chk("R12", "mpelp", d, mpelp[d], 1'b0);
      m_elp[d] = 1'b0; m_sp[d] = 1'b0; m_mp[d] = 1'b0; st_tag[d] = "R12";
    end
    rst_n = 1'b1;
    for (int c = 0; c < N_CYC; c++) begin
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        chk(st_tag[d], "elp", d, elp[d], m_elp[d]);
        chk(st_tag[d], "spelp", d, spelp[d], m_sp[d]);
        chk(st_tag[d], "mpelp", d, mpelp[d], m_mp[d]);
      end
      drive_rand();
      #1;
      for (int d = 0; d < 2; d++) begin
        string t;
        t = !ext ? "R1" : (priv == 2'd0) ? "R2" : (priv == 2'd1) ? "R3" : "R4";
        chk(t, "fcfi_en", d, fcfi[d], ref_en(s_of[d], h_of[d], ext, priv, virt));
        chk("R11", "spelp_swap", d, swp[d], ext && h_of[d] && henv);
        model_step(d);
      end
    end
    @(negedge clk);
    for (int d = 0; d < 2; d++) chk(st_tag[d], "elp", d, elp[d], m_elp[d]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule